// File: doc/BRIEF.md
# Priority-Demoting Destination Sort Network

This block orders eight cells by destination before they enter a multistage routing fabric. Each input lane carries a valid flag, a priority bit, a destination address and a tag that travels with the cell. The network is a bitonic arrangement of two-input compare-exchange elements: three merge phases of one, two and three stages, which gives six stages of four elements each.

Each element orders its two cells by a rank key. An empty lane ranks below every valid cell. A low-priority cell ranks below a high-priority one, whatever the addresses. Within one priority level the smaller address ranks first. When two high-priority cells with the same destination meet, the cell on the element's upper input keeps its priority. The other cell is demoted to low priority and sent toward the element's sink side. Distinct destinations therefore gather at the top of the output, and the extra cells for a destination already in that group fall below it. A parameter chooses between a register after every stage and a purely combinational network.

Top module: `dest_sort_net`

## Requirements
- R1: In the registered variant, while `rst_n` is low and until valid cells have crossed all stages after release, every `out_vld` bit is 0.
- R2: Every element computes a rank key for each cell. An empty cell has the largest key. For a valid cell the key is {~hi, addr}, where hi=1 means high priority. An ascending element puts the smaller key on its upper output (lower index). A descending element puts it on its lower output. Equal keys that are not a collision keep their lanes.
- R3: When both inputs of an element are valid and high priority with equal addresses, the cell from the upper input keeps hi=1. The other cell leaves with hi=0 on the lower output of an ascending element or the upper output of a descending one.
- R4: When no two valid high-priority inputs share an address, output lanes 0..7 hold the cells in ascending key order: high-priority cells by address, then low-priority cells by address, then empty lanes.
- R5: The valid outputs always occupy lanes 0..k-1, where k is the number of valid inputs.
- R6: Every input tag appears on exactly one output lane, with its valid flag and, for valid cells, its address unchanged.
- R7: A cell's priority is never raised. When exactly one pair of valid high-priority inputs shares an address, exactly one cell of that pair leaves with hi=1. Every address held by high-priority inputs keeps at least one high-priority valid output.
- R8: With PIPELINED=1, a new set of eight cells is accepted every cycle and appears at the outputs log2(N)(log2(N)+1)/2 = 6 clock cycles later. With PIPELINED=0 the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the stage registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 8 | Lane valid flags; bit i is lane i, lane 0 is the top |
| in_hi | input | 8 | Lane priority, 1 = high |
| in_addr | input | 24 | Lane destination addresses, 3 bits per lane, lane i at bits [3i+2:3i] |
| in_tag | input | 64 | Lane tags, 8 bits per lane |
| out_vld | output | 8 | Sorted lane valid flags |
| out_hi | output | 8 | Sorted lane priority after demotion |
| out_addr | output | 24 | Sorted lane destination addresses |
| out_tag | output | 64 | Sorted lane tags |

## Verification
The checker watches every element on every cycle. It checks that the rank order holds between each element's two outputs, that a same-address high-priority collision keeps the upper-input tag at high priority and demotes its partner, that each stage conserves valid cells and never adds high-priority ones, and that valid outputs stay packed at the top. The end-to-end effects of the network can only be shown by the bench's scenarios: full ordering of collision-free sets, a single demotion per duplicated destination, survival of every requested destination, tag permutation, and the six-cycle latency against the combinational variant. These scenarios are random lane sets plus directed cases such as all-equal destinations, reversed addresses and a lone cell on the last lane.

// File: rtl/dsn_pkg.sv
package dsn_pkg;

  localparam int ADDR_W = 3;
  localparam int TAG_W  = 8;
  localparam int KEY_W  = ADDR_W + 2;

  typedef struct packed {
    logic              vld;
    logic              hi;
    logic [ADDR_W-1:0] addr;
    logic [TAG_W-1:0]  tag;
  } cell_t;

  localparam cell_t EMPTY_CELL = '0;

  // Smaller key ranks nearer the top; empty lanes take the largest key.
  function automatic logic [KEY_W-1:0] rank_key(cell_t c);
    return c.vld ? {1'b0, ~c.hi, c.addr} : {KEY_W{1'b1}};
  endfunction

  function automatic logic hi_clash(cell_t a, cell_t b);
    return a.vld & b.vld & a.hi & b.hi & (a.addr == b.addr);
  endfunction

endpackage

// File: rtl/dsn_cmpx.sv
module dsn_cmpx
  import dsn_pkg::*;
#(
  parameter bit DESCEND = 1'b0
) (
  input  cell_t up_i,
  input  cell_t dn_i,
  output cell_t up_o,
  output cell_t dn_o
);

  logic [KEY_W-1:0] k_up;
  logic [KEY_W-1:0] k_dn;
  logic             clash;
  logic             hold;
  cell_t            demoted;

  always_comb begin
    k_up        = rank_key(up_i);
    k_dn        = rank_key(dn_i);
    clash       = hi_clash(up_i, dn_i);
    demoted     = dn_i;
    demoted.hi  = 1'b0;
    hold        = DESCEND ? (k_up >= k_dn) : (k_up <= k_dn);

    if (clash) begin
      if (DESCEND) begin
        up_o = demoted;
        dn_o = up_i;
      end else begin
        up_o = up_i;
        dn_o = demoted;
      end
    end else if (hold) begin
      up_o = up_i;
      dn_o = dn_i;
    end else begin
      up_o = dn_i;
      dn_o = up_i;
    end
  end

endmodule

// File: rtl/dsn_rst_sync.sv
module dsn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dsn_stage.sv
module dsn_stage
  import dsn_pkg::*;
#(
  parameter int N_IN      = 8,
  parameter int BLK_LOG   = 1,
  parameter int SPAN_LOG  = 0,
  parameter bit PIPELINED = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  cell_t din   [N_IN],
  output cell_t mix_o [N_IN],
  output cell_t dout  [N_IN]
);

  localparam int SPAN  = 1 << SPAN_LOG;
  localparam int N_ELM = N_IN / 2;

  for (genvar e = 0; e < N_ELM; e++) begin : g_elm
    localparam int  UP   = ((e >> SPAN_LOG) << (SPAN_LOG + 1)) | (e & (SPAN - 1));
    localparam int  DN   = UP + SPAN;
    localparam bit  DESC = ((UP >> BLK_LOG) & 1) == 1;

    dsn_cmpx #(
      .DESCEND (DESC)
    ) u_cx (
      .up_i (din[UP]),
      .dn_i (din[DN]),
      .up_o (mix_o[UP]),
      .dn_o (mix_o[DN])
    );
  end

  if (PIPELINED) begin : g_reg
    cell_t lane_q [N_IN];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < N_IN; i++) lane_q[i] <= EMPTY_CELL;
      end else begin
        for (int i = 0; i < N_IN; i++) lane_q[i] <= mix_o[i];
      end
    end

    assign dout = lane_q;
  end else begin : g_flat
    assign dout = mix_o;
  end

endmodule

// File: rtl/dest_sort_net.sv
module dest_sort_net
  import dsn_pkg::*;
#(
  parameter int N_IN      = 8,
  parameter bit PIPELINED = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IN-1:0]          in_vld,
  input  logic [N_IN-1:0]          in_hi,
  input  logic [N_IN*ADDR_W-1:0]   in_addr,
  input  logic [N_IN*TAG_W-1:0]    in_tag,
  output logic [N_IN-1:0]          out_vld,
  output logic [N_IN-1:0]          out_hi,
  output logic [N_IN*ADDR_W-1:0]   out_addr,
  output logic [N_IN*TAG_W-1:0]    out_tag
);

  localparam int LOG_N   = $clog2(N_IN);
  localparam int N_STAGE = LOG_N * (LOG_N + 1) / 2;

  logic  core_rst_n;
  cell_t feed      [N_IN];
  cell_t pipe_q    [N_STAGE][N_IN];
  cell_t stage_mix [N_STAGE][N_IN];

  if (PIPELINED) begin : g_sync
    dsn_rst_sync u_rst_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .rst_sync_n (core_rst_n)
    );
  end else begin : g_nosync
    assign core_rst_n = rst_n;
  end

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      feed[i].vld  = in_vld[i];
      feed[i].hi   = in_hi[i];
      feed[i].addr = in_addr[i*ADDR_W +: ADDR_W];
      feed[i].tag  = in_tag[i*TAG_W +: TAG_W];
    end
  end

  // Phase p merges blocks of 2^p lanes; step q compares lanes 2^q apart.
  for (genvar p = 1; p <= LOG_N; p++) begin : g_phase
    for (genvar q = p - 1; q >= 0; q--) begin : g_step
      localparam int S = p * (p - 1) / 2 + (p - 1 - q);
      cell_t src [N_IN];

      if (S == 0) begin : g_src_in
        assign src = feed;
      end else begin : g_src_prev
        assign src = pipe_q[S-1];
      end

      dsn_stage #(
        .N_IN      (N_IN),
        .BLK_LOG   (p),
        .SPAN_LOG  (q),
        .PIPELINED (PIPELINED)
      ) u_stage (
        .clk   (clk),
        .rst_n (core_rst_n),
        .din   (src),
        .mix_o (stage_mix[S]),
        .dout  (pipe_q[S])
      );
    end
  end

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      out_vld[i]                     = pipe_q[N_STAGE-1][i].vld;
      out_hi[i]                      = pipe_q[N_STAGE-1][i].hi;
      out_addr[i*ADDR_W +: ADDR_W]   = pipe_q[N_STAGE-1][i].addr;
      out_tag[i*TAG_W +: TAG_W]      = pipe_q[N_STAGE-1][i].tag;
    end
  end

endmodule

// File: rtl/dsn_checker.sv
module dsn_checker
  import dsn_pkg::*;
#(
  parameter int N_IN    = 8,
  parameter int LOG_N   = 3,
  parameter int N_STAGE = 6
) (
  input logic  clk,
  input logic  rst_n,
  input cell_t feed      [N_IN],
  input cell_t pipe_q    [N_STAGE][N_IN],
  input cell_t stage_mix [N_STAGE][N_IN]
);

  for (genvar p = 1; p <= LOG_N; p++) begin : g_phase
    for (genvar q = p - 1; q >= 0; q--) begin : g_step
      localparam int S = p * (p - 1) / 2 + (p - 1 - q);
      cell_t           src [N_IN];
      logic [N_IN-1:0] v_src, v_mix, h_src, h_mix;

      if (S == 0) begin : g_src_in
        assign src = feed;
      end else begin : g_src_prev
        assign src = pipe_q[S-1];
      end

      always_comb begin
        for (int i = 0; i < N_IN; i++) begin
          v_src[i] = src[i].vld;
          v_mix[i] = stage_mix[S][i].vld;
          h_src[i] = src[i].vld & src[i].hi;
          h_mix[i] = stage_mix[S][i].vld & stage_mix[S][i].hi;
        end
      end

      AST_STAGE_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(v_src) == $countones(v_mix)); // R6

      AST_NO_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(h_mix) <= $countones(h_src)); // R7

      for (genvar e = 0; e < N_IN / 2; e++) begin : g_elm
        localparam int UP   = ((e >> q) << (q + 1)) | (e & ((1 << q) - 1));
        localparam int DN   = UP + (1 << q);
        localparam bit DESC = ((UP >> p) & 1) == 1;

        if (DESC) begin : g_dsc
          AST_ELEM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            rank_key(stage_mix[S][UP]) >= rank_key(stage_mix[S][DN])); // R2
          AST_CLASH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            hi_clash(src[UP], src[DN]) |->
              (stage_mix[S][DN].hi && stage_mix[S][DN].tag == src[UP].tag &&
               !stage_mix[S][UP].hi)); // R3
        end else begin : g_asc
          AST_ELEM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            rank_key(stage_mix[S][UP]) <= rank_key(stage_mix[S][DN])); // R2
          AST_CLASH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            hi_clash(src[UP], src[DN]) |->
              (stage_mix[S][UP].hi && stage_mix[S][UP].tag == src[UP].tag &&
               !stage_mix[S][DN].hi)); // R3
        end
      end
    end
  end

  logic [N_IN:0] out_v_ext;

  always_comb begin
    out_v_ext = '0;
    for (int i = 0; i < N_IN; i++) out_v_ext[i] = pipe_q[N_STAGE-1][i].vld;
  end

  AST_VALID_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_v_ext + 1'b1) & out_v_ext) == '0); // R5

endmodule

bind dest_sort_net dsn_checker #(
  .N_IN    (N_IN),
  .LOG_N   (LOG_N),
  .N_STAGE (N_STAGE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .feed      (feed),
  .pipe_q    (pipe_q),
  .stage_mix (stage_mix)
);

// File: tb/dest_sort_net_test.sv
module dest_sort_net_test;
  import dsn_pkg::*;

  localparam int N   = 8;
  localparam int AW  = ADDR_W;
  localparam int TW  = TAG_W;
  localparam int LAT = 6;
  localparam int NV  = 308;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [N-1:0]    in_vld, in_hi;
  logic [N*AW-1:0] in_addr;
  logic [N*TW-1:0] in_tag;
  logic [N-1:0]    p_vld, p_hi, f_vld, f_hi;
  logic [N*AW-1:0] p_addr, f_addr;
  logic [N*TW-1:0] p_tag, f_tag;

  dest_sort_net #(.N_IN(N), .PIPELINED(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_hi(in_hi),
    .in_addr(in_addr), .in_tag(in_tag), .out_vld(p_vld), .out_hi(p_hi),
    .out_addr(p_addr), .out_tag(p_tag));

  dest_sort_net #(.N_IN(N), .PIPELINED(1'b0)) uut_flat (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_hi(in_hi),
    .in_addr(in_addr), .in_tag(in_tag), .out_vld(f_vld), .out_hi(f_hi),
    .out_addr(f_addr), .out_tag(f_tag));

  logic [N-1:0]    hv [NV];
  logic [N-1:0]    hh [NV];
  logic [N*AW-1:0] ha [NV];
  logic [N*TW-1:0] ht [NV];
  int              hk [NV];
  int              hpa [NV];
  int              hpb [NV];

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  task automatic tally(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [KEY_W-1:0] bkey(logic v, logic h, logic [AW-1:0] a);
    return v ? {1'b0, ~h, a} : {KEY_W{1'b1}};
  endfunction

  function automatic logic [AW-1:0] aof(logic [N*AW-1:0] vec, int i);
    return vec[i*AW +: AW];
  endfunction

  function automatic logic [TW-1:0] tof(logic [N*TW-1:0] vec, int i);
    return vec[i*TW +: TW];
  endfunction

  task automatic put(input int vn, input int i, input logic v, input logic h,
                     input int a);
    hv[vn][i] = v;
    hh[vn][i] = h;
    ha[vn][i*AW +: AW] = AW'(a);
    ht[vn][i*TW +: TW] = {5'($urandom), 3'(i)};
  endtask

  // Random lanes with no two valid high cells on one address.
  task automatic gen_clean(input int vn);
    for (int i = 0; i < N; i++) begin
      logic v;
      logic h;
      int   a;
      v = ($urandom % 4) != 0;
      h = $urandom % 2;
      a = $urandom % (1 << AW);
      for (int k = 0; k < i; k++)
        if (v && h && hv[vn][k] && hh[vn][k] && aof(ha[vn], k) == AW'(a)) h = 1'b0;
      put(vn, i, v, h, a);
    end
  endtask

  task automatic gen_pair(input int vn, input int pa, input int pb, input int a);
    gen_clean(vn);
    for (int i = 0; i < N; i++)
      if (hv[vn][i] && aof(ha[vn], i) == AW'(a)) hh[vn][i] = 1'b0;
    put(vn, pa, 1'b1, 1'b1, a);
    put(vn, pb, 1'b1, 1'b1, a);
    hk[vn] = 1; hpa[vn] = pa; hpb[vn] = pb;
  endtask

  task automatic build_all();
    for (int vn = 0; vn < NV; vn++) begin
      hk[vn] = 0; hpa[vn] = 0; hpb[vn] = 0;
    end
    for (int i = 0; i < N; i++) put(0, i, 1'b1, 1'b1, N - 1 - i);      // reversed
    for (int i = 0; i < N; i++) put(1, i, 1'b0, 1'b1, i);              // all empty
    for (int i = 0; i < N; i++) put(2, i, 1'b1, 1'b0, $urandom % 4);   // all low
    gen_pair(3, 0, 1, 5);
    gen_pair(4, 0, 7, 2);
    for (int i = 0; i < N; i++) put(5, i, 1'b1, 1'b1, 2);              // all same
    hk[5] = 2;
    gen_clean(6);
    for (int i = 0; i < N; i++) if (aof(ha[6], i) == 3'd3) hh[6][i] = 1'b0;
    put(6, 0, 1'b1, 1'b0, 3);
    put(6, 7, 1'b1, 1'b1, 3);
    for (int i = 0; i < N; i++) put(7, i, 1'b0, 1'b0, 0);
    put(7, 7, 1'b1, 1'b0, 6);                                           // lone cell
    for (int vn = 8; vn < NV; vn++) begin
      int kind;
      kind = $urandom % 3;
      if (kind == 0) gen_clean(vn);
      else if (kind == 1) begin
        int pa;
        int pb;
        pa = $urandom % N;
        pb = (pa + 1 + ($urandom % (N - 1))) % N;
        gen_pair(vn, pa, pb, $urandom % (1 << AW));
      end else begin
        for (int i = 0; i < N; i++)
          put(vn, i, ($urandom % 4) != 0, $urandom % 2, $urandom % (1 << AW));
        hk[vn] = 2;
      end
    end
  endtask

  task automatic judge(input int vn, input string who,
                       input logic [N-1:0] ov, input logic [N-1:0] oh,
                       input logic [N*AW-1:0] oa, input logic [N*TW-1:0] ot);
    logic [KEY_W-1:0] ek [N];
    logic [N-1:0]     vmask;
    bit               ok, no_raise;
    int               nv, hin, hout;
    string            tagx;
    tagx = $sformatf("%s vec %0d", who, vn);

    nv = $countones(hv[vn]);
    vmask = '0;
    for (int k = 0; k < nv; k++) vmask[k] = 1'b1;
    tally(ov == vmask, "R5", {tagx, " valid packing"}, 64'(ov), 64'(vmask));

    ok = 1'b1; no_raise = 1'b1;
    for (int i = 0; i < N; i++) begin
      int hits;
      hits = 0;
      for (int k = 0; k < N; k++)
        if (tof(ot, k) == tof(ht[vn], i)) begin
          hits++;
          if (ov[k] != hv[vn][i]) ok = 1'b0;
          if (hv[vn][i] && aof(oa, k) != aof(ha[vn], i)) ok = 1'b0;
          if (ov[k] && oh[k] && !hh[vn][i]) no_raise = 1'b0;
        end
      if (hits != 1) ok = 1'b0;
    end
    tally(ok, "R6", {tagx, " tag permutation"}, 64'(ot), 64'(ht[vn]));
    tally(no_raise, "R7", {tagx, " no priority raise"}, 64'(oh), 64'(hh[vn]));

    hin = $countones(hv[vn] & hh[vn]);
    hout = $countones(ov & oh);

    if (hk[vn] == 0) begin
      int bad_pos;
      for (int i = 0; i < N; i++) ek[i] = bkey(hv[vn][i], hh[vn][i], aof(ha[vn], i));
      for (int i = 1; i < N; i++)
        for (int k = i; k > 0; k--)
          if (ek[k] < ek[k-1]) begin
            logic [KEY_W-1:0] t;
            t = ek[k]; ek[k] = ek[k-1]; ek[k-1] = t;
          end
      bad_pos = -1;
      for (int k = 0; k < N; k++)
        if (bad_pos < 0 && bkey(ov[k], oh[k], aof(oa, k)) != ek[k]) bad_pos = k;
      tally(bad_pos < 0, "R2 R4", {tagx, " full order"},
            bad_pos < 0 ? 64'd0 : 64'(bkey(ov[bad_pos], oh[bad_pos], aof(oa, bad_pos))),
            bad_pos < 0 ? 64'd0 : 64'(ek[bad_pos]));
    end else if (hk[vn] == 1) begin
      int pair_hi;
      pair_hi = 0;
      for (int k = 0; k < N; k++)
        if (ov[k] && oh[k] &&
            (tof(ot, k) == tof(ht[vn], hpa[vn]) || tof(ot, k) == tof(ht[vn], hpb[vn])))
          pair_hi++;
      tally(pair_hi == 1 && hout == hin - 1, "R3 R7", {tagx, " single demotion"},
            64'(hout), 64'(hin - 1));
    end else begin
      bit kept;
      kept = 1'b1;
      for (int a = 0; a < (1 << AW); a++) begin
        bit want, have;
        want = 1'b0; have = 1'b0;
        for (int i = 0; i < N; i++) begin
          if (hv[vn][i] && hh[vn][i] && aof(ha[vn], i) == AW'(a)) want = 1'b1;
          if (ov[i] && oh[i] && aof(oa, i) == AW'(a)) have = 1'b1;
        end
        if (want && !have) kept = 1'b0;
      end
      tally(kept && hout <= hin, "R7", {tagx, " destination kept"},
            64'(hout), 64'(hin));
    end
  endtask

  task automatic drive(input int vn);
    in_vld = hv[vn]; in_hi = hh[vn]; in_addr = ha[vn]; in_tag = ht[vn];
  endtask

  task automatic idle();
    in_vld = '0; in_hi = '0; in_addr = '0; in_tag = '0;
  endtask

  initial begin
    void'($urandom(32'h1c5a2bd3));
    build_all();
    rst_n = 1'b0;
    drive(0);
    repeat (3) @(negedge clk);
    tally(p_vld == '0, "R1", "outputs during reset", 64'(p_vld), 64'd0);
    idle();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tally(p_vld == '0, "R1", "outputs after release", 64'(p_vld), 64'd0);

    for (int m = 0; m < NV + LAT; m++) begin
      @(negedge clk);
      if (m >= LAT) judge(m - LAT, "pipe", p_vld, p_hi, p_addr, p_tag);
      if (m == LAT - 1)
        tally(p_vld == '0, "R8", "pipe one cycle early", 64'(p_vld), 64'd0);
      if (m == LAT)
        tally(p_vld == '1, "R8", "pipe at six cycles", 64'(p_vld), 64'hff);
      if (m < NV) drive(m);
      else idle();
      #1;
      if (m < NV) judge(m, "flat", f_vld, f_hi, f_addr, f_tag);
      if (m == 0)
        tally(f_vld == '1, "R8", "flat same cycle", 64'(f_vld), 64'hff);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule